// File: doc/BRIEF.md
# Two-Byte Result Transmit Sequencer

This block sits in the fast core clock domain and hands result bytes to a serial transmitter that runs on a slower, unrelated clock. A request is either a single byte read out of a register or an ALU result twice the byte width. A register read leaves as one byte frame. An ALU result leaves as two frames, lower half first. Each byte is offered as a level-held data/valid pair, which a level-to-pulse synchronizer carries across to the transmitter.

A main state machine picks the byte to present. A small tracker state machine watches the transmitter's busy flag, already synchronized into this domain. It reports a frame as finished once busy has been seen to rise and then fall. Between the two ALU bytes, valid drops in a dedicated wait state. The block leaves that state only when the synchronized copy of the far-side pulse-generator register reads low, which proves the synchronizer has re-armed. While any request is in progress, an enable to the command decoder is held low so that no new frame is accepted.

Top module: `result_tx_seq`

## Requirements
- R1: Out of reset, tx_valid_o is 0, tx_data_o is 0 and dec_en_o is 1.
- R2: A register read request (rd_valid_i high for one cycle while dec_en_o is 1) produces exactly one byte, equal to rd_data_i.
- R3: An ALU request (alu_valid_i high for one cycle while dec_en_o is 1) produces exactly two bytes: alu_result_i[DW-1:0] first, then alu_result_i[2*DW-1:DW].
- R4: tx_data_o does not change while tx_valid_o stays high.
- R5: Each byte's tx_valid_o stays high until tx_busy_sync_i has been seen high and then low again. Only after that is the byte complete.
- R6: Between the two ALU bytes, tx_valid_o is 0. The upper byte is presented only in the cycle after pg_q_sync_i was sampled 0. While pg_q_sync_i stays 1, valid stays 0.
- R7: dec_en_o is 0 from the cycle after a request is accepted until the cycle after the last byte of that request completes. tx_valid_o is never high while dec_en_o is high.
- R8: If rd_valid_i and alu_valid_i are high in the same accepted cycle, only the two ALU bytes are sent and the read is dropped.
- R9: Requests that arrive while dec_en_o is 0 are ignored: no extra bytes are sent and the bytes in progress are unchanged.
- R10: tx_valid_o rises in the cycle after a request is accepted. dec_en_o rises only in the cycle after a final byte's valid was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Register read result request |
| rd_data_i | input | DW | Register read byte |
| alu_valid_i | input | 1 | ALU result request |
| alu_result_i | input | 2*DW | ALU result, lower half sent first |
| tx_busy_sync_i | input | 1 | Transmitter busy, synchronized to clk_i |
| pg_q_sync_i | input | 1 | Far-side pulse-generator register, synchronized to clk_i |
| tx_data_o | output | DW | Byte offered to the transmitter |
| tx_valid_o | output | 1 | Level valid for tx_data_o |
| dec_en_o | output | 1 | Command decoder enable, low while sending |

## Verification
The assertions check four things on every cycle. The byte stays stable under valid. Valid and the decoder enable are never high together. The upper byte is raised only after the pulse-generator copy was sampled low. The decoder enable returns only right after a final frame. Byte order, byte counts, priority between simultaneous requests, ignored late requests and the hold in the wait state under a stuck-high pulse-generator copy can only be seen through the bench's scenarios. In those scenarios a modelled far side, with its own pulse-generator delay and busy time, answers each frame.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_TX_RD,
    M_TX_LO,
    M_WAIT_HI,
    M_TX_HI
  } main_e;

  typedef enum logic [1:0] {
    T_NONE,
    T_BEGAN,
    T_ENDED
  } trk_e;
endpackage

// File: rtl/rts_track.sv
module rts_track
  import rts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic busy_i,
  output logic done_o
);
  trk_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!active_i) st_d = T_NONE;
    else begin
      unique case (st_q)
        T_NONE:  if (busy_i)  st_d = T_BEGAN;
        T_BEGAN: if (!busy_i) st_d = T_ENDED;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= T_NONE;
    else         st_q <= st_d;
  end

  assign done_o = (st_q == T_ENDED);
endmodule

// File: rtl/rts_main.sv
module rts_main
  import rts_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          alu_valid_i,
  input  logic [RW-1:0] alu_result_i,
  input  logic          done_i,
  input  logic          pg_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          dec_en_o,
  output logic          active_o
);
  main_e         st_q, st_d;
  logic [RW-1:0] hold_q, hold_d;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    unique case (st_q)
      M_IDLE: begin
        // ALU result wins over a simultaneous read
        if (alu_valid_i) begin
          st_d   = M_TX_LO;
          hold_d = alu_result_i;
        end else if (rd_valid_i) begin
          st_d   = M_TX_RD;
          hold_d = {{DW{1'b0}}, rd_data_i};
        end
      end
      M_TX_RD:   if (done_i) st_d = M_IDLE;
      M_TX_LO:   if (done_i) st_d = M_WAIT_HI;
      M_WAIT_HI: if (!pg_i)  st_d = M_TX_HI;
      M_TX_HI:   if (done_i) st_d = M_IDLE;
      default:   st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign active_o   = (st_q == M_TX_RD) || (st_q == M_TX_LO) || (st_q == M_TX_HI);
  assign tx_valid_o = active_o;
  assign dec_en_o   = (st_q == M_IDLE);
  assign tx_data_o  = (st_q == M_TX_HI) ? hold_q[RW-1:DW] : hold_q[DW-1:0];
endmodule

// File: rtl/result_tx_seq.sv
module result_tx_seq #(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          alu_valid_i,
  input  logic [RW-1:0] alu_result_i,
  input  logic          tx_busy_sync_i,
  input  logic          pg_q_sync_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          dec_en_o
);
  logic active, done;

  rts_main #(.DW(DW)) u_main (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i),
    .alu_valid_i  (alu_valid_i),
    .alu_result_i (alu_result_i),
    .done_i       (done),
    .pg_i         (pg_q_sync_i),
    .tx_data_o    (tx_data_o),
    .tx_valid_o   (tx_valid_o),
    .dec_en_o     (dec_en_o),
    .active_o     (active)
  );

  rts_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .busy_i   (tx_busy_sync_i),
    .done_o   (done)
  );
endmodule

// File: rtl/result_tx_seq_chk.sv
module result_tx_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pg_q_sync_i,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_valid_o,
  input logic          dec_en_o
);
  a_r4_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && $past(tx_valid_o)) |-> (tx_data_o == $past(tx_data_o)));

  a_r7_valid_excl_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !dec_en_o);

  a_r6_upper_after_pg_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_valid_o) && !$past(dec_en_o)) |-> !$past(pg_q_sync_i));

  a_r10_en_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_en_o) |-> $past(tx_valid_o));
endmodule

bind result_tx_seq result_tx_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pg_q_sync_i (pg_q_sync_i),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .dec_en_o    (dec_en_o)
);

// File: tb/result_tx_seq_bench.sv
module result_tx_seq_bench;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int RW = 2 * DW;
  localparam int BUSY_LEN = 10;
  localparam int NVEC = 6;
  // kind[25:24]: 1 read, 2 alu, 3 both; rd[23:16]; alu[15:0]
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd1, 8'h5A, 16'h0000},
    {2'd2, 8'h00, 16'hBEEF},
    {2'd1, 8'hFF, 16'h1234},
    {2'd2, 8'h11, 16'h00FF},
    {2'd3, 8'h77, 16'hA55A},
    {2'd2, 8'h00, 16'h8001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_v = 1'b0, alu_v = 1'b0;
  logic [DW-1:0] rd_d = '0;
  logic [RW-1:0] alu_d = '0;
  logic [DW-1:0] tx_data;
  logic tx_valid, dec_en;
  logic busy_sync, pg_sync, pg_force = 1'b0;

  int total = 0, bad = 0;
  int byte_cnt = 0;
  logic [DW-1:0] bytes [8];
  logic prev_v = 1'b0, seen_busy = 1'b0, unstable = 1'b0;
  logic [DW-1:0] last_d = '0;
  logic done_flag = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // far side: level-to-pulse synchronizer and transmitter busy
  logic [3:0] sh;
  int bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      bcnt <= 0;
    end else begin
      sh <= {sh[2:0], tx_valid};
      if (sh[1] && !sh[2]) bcnt <= BUSY_LEN;
      else if (bcnt != 0) bcnt <= bcnt - 1;
    end
  end
  assign busy_sync = (bcnt != 0);
  assign pg_sync = sh[3] | pg_force;

  result_tx_seq #(.DW(DW)) u_result_tx_seq (
    .clk_i(clk), .rst_ni(rst_n), .rd_valid_i(rd_v), .rd_data_i(rd_d),
    .alu_valid_i(alu_v), .alu_result_i(alu_d), .tx_busy_sync_i(busy_sync),
    .pg_q_sync_i(pg_sync), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .dec_en_o(dec_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte collector
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && !prev_v) begin
        if (byte_cnt < 8) bytes[byte_cnt] = tx_data;
        byte_cnt++;
        last_d = tx_data;
        seen_busy = 1'b0;
        unstable = 1'b0;
      end
      if (tx_valid && prev_v && tx_data != last_d) unstable = 1'b1;
      if (tx_valid && busy_sync) seen_busy = 1'b1;
      if (!tx_valid && prev_v) begin
        check(!unstable, "R4 data stable under valid", {31'd0, unstable}, 0);
        check(seen_busy, "R5 busy rise and fall before frame end", {31'd0, seen_busy}, 1);
      end
      prev_v = tx_valid;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (dec_en && !busy_sync && sh == 4'd0) break;
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [DW-1:0] r,
                       input logic [RW-1:0] a);
    @(negedge clk);
    byte_cnt = 0;
    rd_v = kind[0];
    alu_v = kind[1];
    rd_d = r;
    alu_d = a;
    @(negedge clk);
    rd_v = 1'b0;
    alu_v = 1'b0;
    check(tx_valid === 1'b1, "R10 valid one cycle after accept", {31'd0, tx_valid}, 1);
    check(dec_en === 1'b0, "R7 decoder disabled while sending", {31'd0, dec_en}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0 && dec_en === 1'b1 && tx_data === '0, "R1 reset state",
          {22'd0, tx_valid, dec_en, tx_data}, {22'd0, 2'b01, 8'h00});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k;
      logic [DW-1:0] r;
      logic [RW-1:0] a;
      k = VEC[v][25:24];
      r = VEC[v][23:16];
      a = VEC[v][15:0];
      issue(k, r, a);
      wait_idle();
      if (k == 2'd1) begin
        check(byte_cnt == 1, "R2 read byte count", byte_cnt, 1);
        check(bytes[0] == r, "R2 read byte value", bytes[0], r);
      end else begin
        check(byte_cnt == 2, k == 2'd3 ? "R8 both: alu only" : "R3 alu byte count", byte_cnt, 2);
        check(bytes[0] == a[DW-1:0], "R3 lower byte first", bytes[0], a[DW-1:0]);
        check(bytes[1] == a[RW-1:DW], "R3 upper byte second", bytes[1], a[RW-1:DW]);
      end
    end

    // R9: requests during a transfer are ignored
    issue(2'd2, 8'h00, 16'hC3D4);
    repeat (3) @(negedge clk);
    rd_v = 1'b1; rd_d = 8'hEE; alu_v = 1'b1; alu_d = 16'h9999;
    @(negedge clk);
    rd_v = 1'b0; alu_v = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(byte_cnt == 2, "R9 late request ignored (count)", byte_cnt, 2);
    check(bytes[0] == 8'hD4 && bytes[1] == 8'hC3, "R9 late request ignored (data)",
          {bytes[1], bytes[0]}, 16'hC3D4);

    // R6: wait state holds while pulse-generator copy stays high
    pg_force = 1'b1;
    issue(2'd2, 8'h00, 16'h6B2C);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!tx_valid) break;
    end
    begin
      logic held;
      held = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_valid || dec_en) held = 1'b0;
      end
      check(held, "R6 valid low and enable low in wait", {31'd0, held}, 1);
    end
    check(byte_cnt == 1, "R6 upper byte withheld", byte_cnt, 1);
    pg_force = 1'b0;
    wait_idle();
    check(byte_cnt == 2 && bytes[1] == 8'h6B, "R6 upper byte after release",
          {byte_cnt[7:0], bytes[1]}, {8'd2, 8'h6B});
    check(dec_en === 1'b1 && tx_valid === 1'b0, "R7 enable back after last byte",
          {30'd0, dec_en, tx_valid}, 2);

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule